// File: doc/BRIEF.md
# Network controller command/status register

This block is the main command and status word of an Ethernet controller. Software reaches it through an indirect pair of ports. A write to the pointer port selects a register. Accesses to the data port then go to that register. Pointer value 0 selects this 16-bit word. Values 1 to 3 select three further configuration registers that live outside the block. The block forwards writes to those registers and returns their read data only while the controller is stopped.

The word holds seven event flags that the datapath sets with single-cycle pulses: babble, heartbeat failure, missed frame, memory timeout, receive done, transmit done and initialization done. Software clears a flag by writing one to it. Two read-only summary bits are derived from the flags: an error summary and an interrupt summary. The word also holds an interrupt enable, receiver-on and transmitter-on state, and three command bits (stop, start, initialize) with a fixed precedence. The block drives the interrupt request line, the request that starts the initialization-block fetch, and the run enables for the receiver and the transmitter.

Top module: `netctl_csr`

## Requirements
- R1: After reset the word reads 0x0004, with only the stop bit (bit 2) set, and irq, init_req, rx_en and tx_en are all low.
- R2: A data-port write changes the word only when the pointer last written holds 0. A pointer write loads wdata[1:0].
- R3: Each event flag is set by its pulse one clock later and cleared by writing one to its bit. Writing zero leaves the flag unchanged. A pulse that arrives in the same cycle as a clear leaves the flag set. The bit positions are: babble 14, heartbeat fail 13, missed 12, memory timeout 11, receive done 10, transmit done 9, init done 8.
- R4: Bit 15 reads as the OR of bits 14, 13, 12 and 11.
- R5: Bit 7 reads as the OR of bits 14, 12, 11, 10, 9 and 8. Bit 13 does not contribute to it.
- R6: Bit 6 is a plain read/write enable. irq is high exactly while bits 7 and 6 are both one.
- R7: Writing one to bit 2 sets stop and clears every other bit in the same clock, including any event pulse and any start or initialize bit written in that same access.
- R8: Writing one to bit 1 (start) or bit 0 (initialize) sets that bit and clears stop. Writing zero to bits 2, 1 or 0 has no effect. init_req follows bit 0.
- R9: One clock after init done (bit 8) and start (bit 1) first become one together, bit 5 (rx_en) is set unless no_rx is high, and bit 4 (tx_en) is set unless no_tx is high.
- R10: A memory-timeout pulse clears rx_en and tx_en in the same clock that it sets bit 11.
- R11: Pointer values 1 to 3 select configuration register 0 to 2. cfg_wr for that register pulses on a data write, and rdata returns its input slice, only while stop is one. Otherwise cfg_wr stays low and rdata reads zero.
- R12: Bit 3 always reads zero. Writes to bits 15, 7, 5, 4 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_wr | input | 1 | Write strobe for the pointer port |
| data_wr | input | 1 | Write strobe for the data port |
| wdata | input | 16 | Write data shared by both ports |
| rdata | output | 16 | Data-port read value for the selected register |
| cfg_rdata | input | 48 | Read values of configuration registers 2,1,0 (high to low) |
| cfg_wr | output | 3 | Write strobes for configuration registers, gated by stop |
| cfg_wdata | output | 16 | Write data for the configuration registers |
| ev_babble | input | 1 | Transmitter ran past the maximum frame length |
| ev_hbfail | input | 1 | Heartbeat check after transmission failed |
| ev_miss | input | 1 | Frame lost for lack of a receive buffer |
| ev_memto | input | 1 | Memory did not answer a DMA cycle in time |
| ev_rxdone | input | 1 | Receive descriptor updated |
| ev_txdone | input | 1 | Transmit descriptor updated |
| ev_initdone | input | 1 | Initialization block loaded |
| no_rx | input | 1 | Mode input: keep the receiver off at start |
| no_tx | input | 1 | Mode input: keep the transmitter off at start |
| irq | output | 1 | Interrupt request |
| init_req | output | 1 | Request to fetch the initialization block |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |

## Verification
The assertions take each event input to be a pulse that the datapath raises from a clocked source. They also take no_rx and no_tx to be stable while a start is being armed. Pointer and data strobes may coincide with events but never with each other. The bench drives every strobe and event just after a rising edge and drops it after the next one, so each stimulus lasts one clock. The bench holds the mode inputs constant across each start sequence. It never asserts ptr_wr and data_wr together.

// File: rtl/netctl_csr_pkg.sv
package netctl_csr_pkg;

  localparam int WORD_W  = 16;
  localparam int NFLAG   = 7;

  localparam int POS_ERR  = 15;
  localparam int POS_FLG0 = 8;
  localparam int POS_INTR = 7;
  localparam int POS_INEA = 6;
  localparam int POS_RXON = 5;
  localparam int POS_TXON = 4;
  localparam int POS_STOP = 2;
  localparam int POS_STRT = 1;
  localparam int POS_INIT = 0;

  // flag vector index: 0 init done, 1 tx done, 2 rx done, 3 mem timeout,
  // 4 missed, 5 heartbeat fail, 6 babble
  localparam logic [NFLAG-1:0] ERR_MASK  = 7'b1111000;
  localparam logic [NFLAG-1:0] INTR_MASK = 7'b1011111;

  function automatic logic err_of(input logic [NFLAG-1:0] f);
    return |(f & ERR_MASK);
  endfunction

  function automatic logic intr_of(input logic [NFLAG-1:0] f);
    return |(f & INTR_MASK);
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(
    input logic [NFLAG-1:0] f,
    input logic inea, input logic rxon, input logic txon,
    input logic stop, input logic strt, input logic init);
    logic [WORD_W-1:0] w;
    w = '0;
    w[POS_FLG0 +: NFLAG] = f;
    w[POS_ERR]  = err_of(f);
    w[POS_INTR] = intr_of(f);
    w[POS_INEA] = inea;
    w[POS_RXON] = rxon;
    w[POS_TXON] = txon;
    w[POS_STOP] = stop;
    w[POS_STRT] = strt;
    w[POS_INIT] = init;
    return w;
  endfunction

endpackage

// File: rtl/netctl_csr_ptr.sv
module netctl_csr_ptr #(
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] din,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= din;
  end
endmodule

// File: rtl/netctl_csr_flags.sv
module netctl_csr_flags #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] w1c,
  output logic [N-1:0] q
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[k] <= 1'b0;
      else if (clr_all) q[k] <= 1'b0;
      else if (ev[k])   q[k] <= 1'b1;
      else if (w1c[k])  q[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/netctl_csr_cmd.sv
module netctl_csr_cmd (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic w_stop,
  input  logic w_strt,
  input  logic w_init,
  input  logic w_inea,
  input  logic ev_mem,
  input  logic idon,
  input  logic no_rx,
  input  logic no_tx,
  output logic stop_q,
  output logic strt_q,
  output logic init_q,
  output logic inea_q,
  output logic rxon_q,
  output logic txon_q,
  output logic stop_cmd
);
  logic go, go_prev, go_rise;

  assign stop_cmd = wr & w_stop;
  assign go       = idon & strt_q;
  assign go_rise  = go & ~go_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b1; strt_q <= 1'b0; init_q <= 1'b0;
      inea_q <= 1'b0; rxon_q <= 1'b0; txon_q <= 1'b0;
      go_prev <= 1'b0;
    end else if (stop_cmd) begin
      stop_q <= 1'b1; strt_q <= 1'b0; init_q <= 1'b0;
      inea_q <= 1'b0; rxon_q <= 1'b0; txon_q <= 1'b0;
      go_prev <= 1'b0;
    end else begin
      go_prev <= go;
      if (wr && (w_strt || w_init)) stop_q <= 1'b0;
      if (wr && w_strt) strt_q <= 1'b1;
      if (wr && w_init) init_q <= 1'b1;
      if (wr) inea_q <= w_inea;
      if (ev_mem) begin
        rxon_q <= 1'b0;
        txon_q <= 1'b0;
      end else if (go_rise) begin
        if (!no_rx) rxon_q <= 1'b1;
        if (!no_tx) txon_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/netctl_csr.sv
module netctl_csr
  import netctl_csr_pkg::*;
#(
  parameter int PTR_W   = 2,
  parameter int NUM_CFG = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ptr_wr,
  input  logic                       data_wr,
  input  logic [WORD_W-1:0]          wdata,
  output logic [WORD_W-1:0]          rdata,
  input  logic [NUM_CFG*WORD_W-1:0]  cfg_rdata,
  output logic [NUM_CFG-1:0]         cfg_wr,
  output logic [WORD_W-1:0]          cfg_wdata,
  input  logic                       ev_babble,
  input  logic                       ev_hbfail,
  input  logic                       ev_miss,
  input  logic                       ev_memto,
  input  logic                       ev_rxdone,
  input  logic                       ev_txdone,
  input  logic                       ev_initdone,
  input  logic                       no_rx,
  input  logic                       no_tx,
  output logic                       irq,
  output logic                       init_req,
  output logic                       rx_en,
  output logic                       tx_en
);
  logic [PTR_W-1:0]  ptr_q;
  logic              wr_csr0;
  logic              stop_cmd;
  logic [NFLAG-1:0]  ev_vec, flag_q;
  logic              stop_q, strt_q, init_q, inea_q, rxon_q, txon_q;
  logic [WORD_W-1:0] csr_word;

  netctl_csr_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_wr),
    .din(wdata[PTR_W-1:0]), .ptr(ptr_q)
  );

  assign wr_csr0 = data_wr & (ptr_q == '0);
  assign ev_vec  = {ev_babble, ev_hbfail, ev_miss, ev_memto,
                    ev_rxdone, ev_txdone, ev_initdone};

  netctl_csr_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(wr_csr0),
    .w_stop(wdata[POS_STOP]), .w_strt(wdata[POS_STRT]),
    .w_init(wdata[POS_INIT]), .w_inea(wdata[POS_INEA]),
    .ev_mem(ev_memto), .idon(flag_q[0]),
    .no_rx(no_rx), .no_tx(no_tx),
    .stop_q(stop_q), .strt_q(strt_q), .init_q(init_q),
    .inea_q(inea_q), .rxon_q(rxon_q), .txon_q(txon_q),
    .stop_cmd(stop_cmd)
  );

  netctl_csr_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr_all(stop_cmd),
    .ev(ev_vec),
    .w1c(wdata[POS_FLG0 +: NFLAG] & {NFLAG{wr_csr0}}),
    .q(flag_q)
  );

  assign csr_word = pack_word(flag_q, inea_q, rxon_q, txon_q,
                              stop_q, strt_q, init_q);

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    assign cfg_wr[i] = data_wr & stop_q & (ptr_q == PTR_W'(i + 1));
  end
  assign cfg_wdata = wdata;

  always_comb begin
    rdata = '0;
    if (ptr_q == '0) rdata = csr_word;
    for (int i = 0; i < NUM_CFG; i++) begin
      if (stop_q && ptr_q == PTR_W'(i + 1))
        rdata = cfg_rdata[i*WORD_W +: WORD_W];
    end
  end

  assign irq      = intr_of(flag_q) & inea_q;
  assign init_req = init_q;
  assign rx_en    = rxon_q;
  assign tx_en    = txon_q;
endmodule

// File: rtl/netctl_csr_chk.sv
module netctl_csr_chk #(
  parameter int NUM_CFG = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [15:0]        csr_word,
  input logic [15:0]        wdata,
  input logic               wr_csr0,
  input logic               stop_cmd,
  input logic               ev_memto,
  input logic               ev_rxdone,
  input logic [NUM_CFG-1:0] cfg_wr,
  input logic               irq,
  input logic               rx_en,
  input logic               tx_en
);
  assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxdone && !stop_cmd |=> csr_word[10]);

  assert_err_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    csr_word[15] == (|csr_word[14:11]));

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (csr_word[7] && csr_word[6]));

  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> csr_word == 16'h0004);

  assert_start_leaves_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_csr0 && wdata[1] && !wdata[2] |=> csr_word[1] && !csr_word[2]);

  assert_memto_kills_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_memto && !stop_cmd |=> !rx_en && !tx_en && csr_word[11]);

  assert_cfg_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|cfg_wr) |-> csr_word[2]);

  assert_bit3_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_word[3]);
endmodule

bind netctl_csr netctl_csr_chk #(.NUM_CFG(NUM_CFG)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_word(csr_word), .wdata(wdata),
  .wr_csr0(wr_csr0), .stop_cmd(stop_cmd), .ev_memto(ev_memto),
  .ev_rxdone(ev_rxdone), .cfg_wr(cfg_wr), .irq(irq),
  .rx_en(rx_en), .tx_en(tx_en)
);

// File: tb/netctl_csr_test.sv
module netctl_csr_test;
  localparam int CLK_HALF = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_wr = 1'b0, data_wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [47:0] cfg_rdata = {16'hC2C2, 16'hB1B1, 16'hA0A0};
  logic [2:0]  cfg_wr;
  logic [15:0] cfg_wdata;
  logic [6:0]  ev = '0;
  logic        no_rx = 1'b0, no_tx = 1'b0;
  logic        irq, init_req, rx_en, tx_en;
  int          total = 0, bad = 0;

  always #CLK_HALF clk = ~clk;

  netctl_csr uut (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .data_wr(data_wr),
    .wdata(wdata), .rdata(rdata), .cfg_rdata(cfg_rdata), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata),
    .ev_babble(ev[6]), .ev_hbfail(ev[5]), .ev_miss(ev[4]), .ev_memto(ev[3]),
    .ev_rxdone(ev[2]), .ev_txdone(ev[1]), .ev_initdone(ev[0]),
    .no_rx(no_rx), .no_tx(no_tx), .irq(irq), .init_req(init_req),
    .rx_en(rx_en), .tx_en(tx_en)
  );

  // expected word: error summary from flags 6..3, interrupt summary skips flag 5
  function automatic logic [15:0] mk(input logic [6:0] f, input bit inea,
      input bit rx, input bit tx, input bit stop, input bit strt, input bit init);
    logic [15:0] w;
    w = {((f[6] + f[5] + f[4] + f[3]) != 0), f,
         ((f[6] + f[4] + f[3] + f[2] + f[1] + f[0]) != 0),
         inea, rx, tx, 1'b0, stop, strt, init};
    return w;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    ptr_wr = 1'b0; data_wr = 1'b0; ev = '0;
  endtask

  task automatic set_ptr(input logic [1:0] p);
    ptr_wr = 1'b1; wdata = {14'd0, p}; tick();
  endtask

  task automatic wr(input logic [15:0] v);
    data_wr = 1'b1; wdata = v; tick();
  endtask

  task automatic pulse(input logic [6:0] e);
    ev = e; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    #1;
    chk("R1 word", rdata, 16'h0004);
    chk("R1 outs", {12'd0, irq, init_req, rx_en, tx_en}, 16'h0);

    // R11: configuration access while stopped
    set_ptr(2'd1);
    chk("R11 cfg read", rdata, 16'hA0A0);
    data_wr = 1'b1; wdata = 16'h1234; #1;
    chk("R11 cfg wr strobe", {13'd0, cfg_wr}, 16'h0001);
    chk("R11 cfg wdata", cfg_wdata, 16'h1234);
    tick();

    // R8: initialize clears stop
    set_ptr(2'd0);
    wr(16'h0001);
    chk("R8 init", rdata, mk(7'd0, 0, 0, 0, 0, 0, 1));
    chk("R8 init_req", {15'd0, init_req}, 16'h1);

    // R3 R4 R5 R6: sweep every event combination with interrupts enabled
    wr(16'h0041);
    for (int m = 0; m < 128; m++) begin
      pulse(m[6:0]);
      chk("R3 R4 R5 sweep", rdata, mk(m[6:0], 1, 0, 0, 0, 0, 1));
      chk("R6 irq", {15'd0, irq}, {15'd0, (m[6:0] & 7'h5F) != 0});
      wr(16'h7F41);
      chk("R3 w1c", rdata, mk(7'd0, 1, 0, 0, 0, 0, 1));
    end
    wr(16'h0001);
    chk("R6 inea off", rdata, 16'h0001);

    // R3: zero write keeps flags; set beats clear
    pulse(7'b1000100);
    wr(16'h0001);
    chk("R3 zero no effect", rdata, mk(7'b1000100, 0, 0, 0, 0, 0, 1));
    chk("R6 irq needs enable", {15'd0, irq}, 16'h0);
    ev = 7'b0000100; wr(16'h7F01);
    chk("R3 set wins", rdata, mk(7'b0000100, 0, 0, 0, 0, 0, 1));
    wr(16'h7F01);
    chk("R3 cleared", rdata, 16'h0001);

    // R12: read-only and unused bits ignore writes
    wr(16'h80B9);
    chk("R12 ignored", rdata, 16'h0001);

    // R2 R11: pointer 3 while running
    set_ptr(2'd3);
    chk("R11 read gated", rdata, 16'h0000);
    data_wr = 1'b1; wdata = 16'h0004; #1;
    chk("R11 wr gated", {13'd0, cfg_wr}, 16'h0);
    tick();
    set_ptr(2'd0);
    chk("R2 other ptr", rdata, 16'h0001);

    // R9: start then init done, transmitter disabled by mode
    no_tx = 1'b1;
    wr(16'h0002);
    chk("R8 start", rdata, mk(7'd0, 0, 0, 0, 0, 1, 1));
    pulse(7'b0000001);
    chk("R9 idon", rdata, mk(7'b0000001, 0, 0, 0, 0, 1, 1));
    tick();
    chk("R9 rx only", rdata, mk(7'b0000001, 0, 1, 0, 0, 1, 1));
    chk("R9 pins", {14'd0, rx_en, tx_en}, 16'b10);

    // R10: memory timeout
    pulse(7'b0001000);
    chk("R10 merr", rdata, mk(7'b0001001, 0, 0, 0, 0, 1, 1));
    tick();
    chk("R10 stays off", {14'd0, rx_en, tx_en}, 16'b00);
    no_tx = 1'b0;

    // R7: stop beats everything, including events in the same cycle
    ev = 7'h7F; wr(16'h0007);
    chk("R7 stop", rdata, 16'h0004);
    chk("R7 outs", {12'd0, irq, init_req, rx_en, tx_en}, 16'h0);

    // R8 R9: start without init, then init done enables both
    wr(16'h0002);
    chk("R8 start clears stop", rdata, 16'h0002);
    pulse(7'b0000001);
    tick();
    chk("R9 both on", rdata, mk(7'b0000001, 0, 1, 1, 0, 1, 0));
    wr(16'h0000);
    chk("R8 zero write", rdata, mk(7'b0000001, 0, 1, 1, 0, 1, 0));
    chk("R9 pins both", {14'd0, rx_en, tx_en}, 16'b11);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule